// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block gives one processor a free-running cycle counter and a single compare register, both reached through one register address. A read of that address returns the live counter value. A write to it loads the compare register and never touches the counter. The counter is 32 or 64 bits wide, set by a parameter. The compare register covers only the low bits of the counter, 32 bits by default.

When the low bits of the counter equal the compare value, a sticky pending flag is set. The interrupt output is that flag gated by a mask input. An acknowledge pulse clears the flag. Software programs the next event by writing a value ahead of the counter. A value that is already behind the counter fires only once the low bits wrap around and reach it again.

Each instance counts on its own. Nothing ties it to any other instance.

Top module: `cyc_alarm_timer`

## Requirements
- R1: After reset the counter reads 0, the compare register holds all ones and the interrupt is not pending. With no write, the first event therefore happens when the low bits reach all ones.
- R2: The counter adds exactly 1 on every clock cycle. `rd_data` always shows the current counter value.
- R3: A write strobe loads `wr_data` into the compare register in the next cycle. The counter keeps its +1 sequence through the write.
- R4: A match sets the pending flag at the next clock edge. A match is the low `CMP_W` bits of the counter equal to the compare register.
- R5: The pending flag holds until an acknowledge is seen. An acknowledge in a cycle with no match clears it at that edge.
- R6: An acknowledge in the same cycle as a match leaves the pending flag set.
- R7: `irq_req` is the pending flag ANDed with the inverse of `irq_mask`. A match while masked still sets the flag, and the flag appears on the output once the mask drops.
- R8: A compare value written behind the low counter bits raises nothing until those bits wrap past all ones and reach the value again.
- R9: The counter wraps from all ones to 0 at its full width `CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the shared address (loads the compare register) |
| wr_data | input | CMP_W | Compare value to load |
| rd_data | output | CNT_W | Current counter value (read of the shared address) |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| irq_ack | input | 1 | Clears the pending flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a compare value that lies behind the counter. It must stay silent for almost a full turn of the low bits and then fire. At a 32-bit compare width that takes billions of cycles. The bench therefore builds the block with an 8-bit compare and a 16-bit counter, so a full low-bit turn and a full counter wrap both fit in a short run. A match with an acknowledge in the same cycle is reached by holding the acknowledge high across a window that contains a known match. The reference model then tracks the pending flag cycle by cycle through that window.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef struct packed {
        logic pend;
    } pend_state_t;

    function automatic logic next_pend(input logic cur, input logic hit, input logic ack);
        return hit | (cur & ~ack);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count == $past(count) + ONE); // R2

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    output logic [CMP_W-1:0] cmp_val
);
    typedef struct packed {
        logic [CMP_W-1:0] value;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.value = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{value: '1};
        else        st_q <= st_d;
    end

    assign cmp_val = st_q.value;

    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cmp_val == $past(wr_data)); // R3
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cmp_val)); // R3

endmodule

// File: rtl/tmr_pending.sv
module tmr_pending
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    output logic pend
);
    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = next_pend(st_q.pend, hit, ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend); // R4
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend); // R5
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ack && !hit) |=> !pend); // R5
    AST_ACK_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ack) |=> pend); // R6

endmodule

// File: rtl/cyc_alarm_timer.sv
module cyc_alarm_timer #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_mask,
    input  logic             irq_ack,
    output logic             irq_req
);
    logic [CNT_W-1:0] count;
    logic [CMP_W-1:0] cmp_val;
    logic [CMP_W-1:0] low_bits;
    logic             hit;
    logic             pend;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    tmr_compare #(.CMP_W(CMP_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmp_val (cmp_val)
    );

    assign low_bits = count[CMP_W-1:0];
    assign hit      = (low_bits == cmp_val);

    tmr_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .ack   (irq_ack),
        .pend  (pend)
    );

    assign rd_data = count;
    assign irq_req = pend & ~irq_mask;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_req); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !hit) |=> !pend); // R8

endmodule

// File: tb/cyc_alarm_timer_test.sv
`timescale 1ns/1ps
module cyc_alarm_timer_test;
    localparam int CNT_W = 16;
    localparam int CMP_W = 8;
    localparam longint CMASK = (64'd1 << CMP_W) - 1;
    localparam longint NMASK = (64'd1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [CMP_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic irq_mask = 1'b0;
    logic irq_ack = 1'b0;
    logic irq_req;

    always #2.5 clk = ~clk;

    cyc_alarm_timer #(.CNT_W(CNT_W), .CMP_W(CMP_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_mask(irq_mask), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    int total = 0;
    int bad = 0;
    string cur_tag = "R2";
    bit running = 1'b0;

    longint m_cnt = 0;
    longint m_cmp = CMASK;
    bit m_pend = 1'b0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = CMASK; m_pend = 1'b0;
        end else begin
            bit hit;
            hit = ((m_cnt & CMASK) == m_cmp);
            m_pend = hit || (m_pend && !irq_ack);
            if (wr_en) m_cmp = longint'(wr_data);
            m_cnt = (m_cnt + 1) & NMASK;
        end
    end

    // compare against the reference on every falling edge
    always @(negedge clk) begin
        if (running) begin
            check(longint'(rd_data) == m_cnt, "R2", longint'(rd_data), m_cnt);
            check(irq_req == (m_pend && !irq_mask), cur_tag, longint'(irq_req),
                  longint'(m_pend && !irq_mask));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_write(longint v);
        wr_en = 1'b1; wr_data = CMP_W'(v);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1000000;
        check(1'b0, "WATCHDOG", 0, 1);
        finish_run();
    end

    initial begin
        longint prev;
        longint wait_n;
        step(3);
        // R1: reset state visible at the ports
        check(rd_data == 0, "R1", longint'(rd_data), 0);
        check(irq_req == 1'b0, "R1", longint'(irq_req), 0);
        rst_n = 1'b1;
        running = 1'b1;

        // R1: all-ones compare fires when low bits reach all ones
        cur_tag = "R1";
        step(300);
        check(irq_req == 1'b1, "R1", longint'(irq_req), 1);

        // R5: acknowledge clears, and the flag stays clear after
        cur_tag = "R5";
        pulse_ack();
        check(irq_req == 1'b0, "R5", longint'(irq_req), 0);
        step(5);
        check(irq_req == 1'b0, "R5", longint'(irq_req), 0);

        // R3: write leaves the counter sequence intact
        cur_tag = "R3";
        prev = longint'(rd_data);
        do_write((m_cnt + 12) & CMASK);
        check(longint'(rd_data) == ((prev + 1) & NMASK), "R3", longint'(rd_data), (prev + 1) & NMASK);

        // R4: future compare fires
        cur_tag = "R4";
        step(20);
        check(irq_req == 1'b1, "R4", longint'(irq_req), 1);
        pulse_ack();

        // R7: masked match still sets pending
        cur_tag = "R7";
        irq_mask = 1'b1;
        do_write((m_cnt + 6) & CMASK);
        step(15);
        check(irq_req == 1'b0, "R7", longint'(irq_req), 0);
        irq_mask = 1'b0;
        #0.5;
        check(irq_req == 1'b1, "R7", longint'(irq_req), 1);
        step(1);
        pulse_ack();

        // R6: ack held across a match window
        cur_tag = "R6";
        do_write((m_cnt + 8) & CMASK);
        irq_ack = 1'b1;
        step(30);
        irq_ack = 1'b0;
        step(2);

        // R8: compare behind the counter waits for the low bits to wrap
        cur_tag = "R8";
        do_write((m_cnt - 5) & CMASK);
        step(200);
        check(irq_req == 1'b0, "R8", longint'(irq_req), 0);
        step(70);
        check(irq_req == 1'b1, "R8", longint'(irq_req), 1);
        pulse_ack();

        // R9: full-width counter wrap
        cur_tag = "R9";
        irq_mask = 1'b1;
        wait_n = (NMASK + 1) - m_cnt + 3;
        step(int'(wait_n));
        check(longint'(rd_data) < 10 && longint'(rd_data) == m_cnt, "R9", longint'(rd_data), m_cnt);
        irq_mask = 1'b0;
        step(2);

        running = 1'b0;
        finish_run();
    end
endmodule